// File: doc/BRIEF.md
# Banked Register Bus Interface

This block is the processor-facing side of a serial controller. The processor sees only eight byte addresses. It sees them through an active-low chip select, read strobe and write strobe, and a bidirectional 8-bit data bus. Behind those eight addresses sit roughly forty registers.

Which register an access reaches depends on three things:
- a 2-bit bank number;
- a divisor-latch access bit;
- whether the access is a read or a write, since several addresses read one register and write another.

The block decodes each access and keeps the configuration registers with their reset values. It also keeps read-only status shadows that the serial engines load. Every write target, stored or command-only, gets a one-cycle strobe, so neighbouring blocks can react to writes.

Bus strobes are asynchronous to the block clock. Writes are captured by a two-stage sampler and commit on the clock after the write strobe is seen rising. Reads are a combinational path from address to data bus, open only while chip select and read strobe are both low. The block has no back-pressure. Every bus cycle completes.

Top module: `bankreg_bus`

## Requirements
- R1: After reset the configuration outputs hold these values, and reads return them:
  - Values by register: aux0 00, aux1 00, bga_cfg 04, bga_hi 00, bga_lo 02, bgb_cfg 84, bgb_hi 00, bgb_lo 05, clk_cfg 00, fifo_mode 00, gen_en 00, io_mode 0C, line_ctl 00, line_sts 60, modem_ctl 00, modem_ie 0F, modem_sts 00, pwr_mode FC, rx_ie 1E, rx_mode 00, tx_mode 00, timer_ie 00.
  - These are `cfg_q` bytes 0 to 21 in that order.
  - Status shadows: gen_sts 12, timer_sts 30, all others 00.
  - The bank is 00.
- R2: Bank selection at address 010:
  - A write at 010 in any bank sets the bank to data bits [6:5].
  - A read at 010 returns {0, bank[1:0], 0000, irq_idle}, which is 00000001 after reset with irq_idle high.
  - Nothing else is stored at 010.
- R3: The divisor-latch bit is bit 7 of line_ctl.
  - Bank 00 with the bit at 1: addresses 000 and 001 are bga_lo and bga_hi.
  - Bank 00 with the bit at 0: 000 reads rx_data and writes the tx_data command, and 001 is gen_en.
  - Bank 00 other addresses: 011 line_ctl, 100 modem_ctl, 101 line_sts, 110 modem_sts, 111 aux0.
- R4: Bank 11 decode:
  - With the divisor-latch bit at 1: 000 is bgb_lo and 001 is bgb_hi.
  - With the bit at 0: 000 is clk_cfg and 001 is bga_cfg.
  - Other addresses: 011 bgb_cfg, 100 pwr_mode, 101 modem_ie, 110 timer_ie.
  - 111 reads 00 and ignores writes.
- R5: Bank 01 has separate read and write targets (read / write):
  - 000: rx_data / tx_data command
  - 001: rx_frame / tx_frame command
  - 011: timer_sts / timer command
  - 100: fifo_lvl / modem_ctl
  - 101: rx_sts / rx command
  - 110: modem_sts / tx command
  - 111: gen_sts / irq command
- R6: Bank 10 and bus writes:
  - Bank 10 decode: 001 fifo_mode, 011 tx_mode, 100 io_mode, 101 aux1, 110 rx_ie, 111 rx_mode, and 000 unmapped.
  - A write commits only if chip select was low while the write strobe was low. Commit follows the strobe's rising edge.
  - `wr_stb` pulses for exactly one clock, on the second clock edge after the rise, with `wr_data` holding the written byte.
- R7: `wr_stb` bit order:
  - Bits 0-21 are the configuration registers in R1 order.
  - Bits 22-27 are the irq, rx, tx, timer, tx_data and tx_frame commands.
  - Bit 28 is the bank select.
  - A command write pulses its bit and changes no readable register.
- R8: The block drives the data bus only while chip select and read strobe are both low, and is high-impedance otherwise.
- R9: `sts_load` bit j copies `sts_data` into status shadow j on that clock. The shadow order is fifo_lvl, gen_sts, rx_sts, rx_frame, timer_sts, rx_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 3 | Register address |
| bus_data | inout | 8 | Bidirectional data bus |
| irq_idle | input | 1 | Reported in bit 0 of the address-010 read |
| sts_load | input | 6 | Per-shadow status load enables |
| sts_data | input | 8 | Status value to load |
| wr_stb | output | 29 | One-cycle per-target write strobes |
| wr_data | output | 8 | Byte accompanying a write strobe |
| cfg_q | output | 176 | All configuration registers, byte i = register i |

## Verification
Each kind of wrong internal state shows at the ports differently:
- **Wrong bank or divisor-latch bit:** shows on the very next read. Whole rows of addresses return the neighbouring bank's registers, so reads are swept over every bank, address and latch setting, both at reset values and after distinct patterns are written.
- **Misrouted write:** shows in `cfg_q` two clocks after the strobe rises. That is why `cfg_q` is compared to a behavioural model on every clock.
- **Wrong strobe index:** shows in the same cycle as the write commits.
- **Command write that stored data:** shows as a readback mismatch at the shared address.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int DW    = 8;
  localparam int AW    = 3;
  localparam int BW    = 2;
  localparam int NCFG  = 22;
  localparam int NCMD  = 6;
  localparam int NSTS  = 6;
  localparam int NWR   = NCFG + NCMD + 1;
  localparam int CW    = $clog2(NWR + 3);

  // configuration register indices
  localparam int IX_AUX0 = 0,  IX_AUX1 = 1,  IX_BGA_CFG = 2,  IX_BGA_HI = 3;
  localparam int IX_BGA_LO = 4, IX_BGB_CFG = 5, IX_BGB_HI = 6, IX_BGB_LO = 7;
  localparam int IX_CLK_CFG = 8, IX_FIFO_MODE = 9, IX_GEN_EN = 10, IX_IO_MODE = 11;
  localparam int IX_LINE_CTL = 12, IX_LINE_STS = 13, IX_MODEM_CTL = 14, IX_MODEM_IE = 15;
  localparam int IX_MODEM_STS = 16, IX_PWR_MODE = 17, IX_RX_IE = 18, IX_RX_MODE = 19;
  localparam int IX_TX_MODE = 20, IX_TIMER_IE = 21;
  localparam int DLAB_BIT = 7;
  localparam int BANK_LSB = 5;

  // write codes beyond the stored registers
  localparam int WC_IRQ = NCFG + 0, WC_RX = NCFG + 1, WC_TX = NCFG + 2;
  localparam int WC_TIMER = NCFG + 3, WC_TXDATA = NCFG + 4, WC_TXFRAME = NCFG + 5;
  localparam int WC_BANK = NCFG + NCMD;

  // read codes beyond the stored registers
  localparam int RC_FIFO = NCFG + 0, RC_GEN = NCFG + 1, RC_RXSTS = NCFG + 2;
  localparam int RC_RXFRAME = NCFG + 3, RC_TIMER = NCFG + 4, RC_RXDATA = NCFG + 5;
  localparam int RC_IDENT = NCFG + NSTS;
  localparam int CODE_NONE = (1 << CW) - 1;

  function automatic logic [DW-1:0] cfg_default(input int i);
    case (i)
      IX_BGA_CFG:  return 8'h04;
      IX_BGA_LO:   return 8'h02;
      IX_BGB_CFG:  return 8'h84;
      IX_BGB_LO:   return 8'h05;
      IX_IO_MODE:  return 8'h0C;
      IX_LINE_STS: return 8'h60;
      IX_MODEM_IE: return 8'h0F;
      IX_PWR_MODE: return 8'hFC;
      IX_RX_IE:    return 8'h1E;
      default:     return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] sts_default(input int j);
    case (j)
      1:       return 8'h12;
      4:       return 8'h30;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/bankreg_sampler.sv
module bankreg_sampler
  import bankreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  typedef struct packed {
    logic          cs_n;
    logic          wr_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } samp_t;

  samp_t s1, s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '{cs_n: 1'b1, wr_n: 1'b1, addr: '0, data: '0};
      s2 <= '{cs_n: 1'b1, wr_n: 1'b1, addr: '0, data: '0};
    end else begin
      s1 <= '{cs_n: cs_n, wr_n: wr_n, addr: addr, data: data};
      s2 <= s1;
    end
  end

  // write strobe released while the previous sample showed a selected write
  assign wr_evt  = !s2.cs_n && !s2.wr_n && s1.wr_n;
  assign wr_addr = s2.addr;
  assign wr_data = s2.data;

  // R6: a commit lasts a single clock
  p_wr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
endmodule

// File: rtl/bankreg_decode.sv
module bankreg_decode
  import bankreg_pkg::*;
(
  input  logic [BW-1:0] bank,
  input  logic          dlab,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] wr_addr,
  output logic [CW-1:0] rd_code,
  output logic [CW-1:0] wr_code
);
  function automatic logic [CW-1:0] c(input int v);
    return CW'(v);
  endfunction

  always_comb begin
    case ({bank, wr_addr})
      5'b00_000: wr_code = dlab ? c(IX_BGA_LO) : c(WC_TXDATA);
      5'b00_001: wr_code = dlab ? c(IX_BGA_HI) : c(IX_GEN_EN);
      5'b00_011: wr_code = c(IX_LINE_CTL);
      5'b00_100: wr_code = c(IX_MODEM_CTL);
      5'b00_101: wr_code = c(IX_LINE_STS);
      5'b00_110: wr_code = c(IX_MODEM_STS);
      5'b00_111: wr_code = c(IX_AUX0);
      5'b01_000: wr_code = c(WC_TXDATA);
      5'b01_001: wr_code = c(WC_TXFRAME);
      5'b01_011: wr_code = c(WC_TIMER);
      5'b01_100: wr_code = c(IX_MODEM_CTL);
      5'b01_101: wr_code = c(WC_RX);
      5'b01_110: wr_code = c(WC_TX);
      5'b01_111: wr_code = c(WC_IRQ);
      5'b10_001: wr_code = c(IX_FIFO_MODE);
      5'b10_011: wr_code = c(IX_TX_MODE);
      5'b10_100: wr_code = c(IX_IO_MODE);
      5'b10_101: wr_code = c(IX_AUX1);
      5'b10_110: wr_code = c(IX_RX_IE);
      5'b10_111: wr_code = c(IX_RX_MODE);
      5'b11_000: wr_code = dlab ? c(IX_BGB_LO) : c(IX_CLK_CFG);
      5'b11_001: wr_code = dlab ? c(IX_BGB_HI) : c(IX_BGA_CFG);
      5'b11_011: wr_code = c(IX_BGB_CFG);
      5'b11_100: wr_code = c(IX_PWR_MODE);
      5'b11_101: wr_code = c(IX_MODEM_IE);
      5'b11_110: wr_code = c(IX_TIMER_IE);
      default:   wr_code = (wr_addr == 3'b010) ? c(WC_BANK) : c(CODE_NONE);
    endcase
  end

  always_comb begin
    case ({bank, rd_addr})
      5'b00_000: rd_code = dlab ? c(IX_BGA_LO) : c(RC_RXDATA);
      5'b00_001: rd_code = dlab ? c(IX_BGA_HI) : c(IX_GEN_EN);
      5'b00_011: rd_code = c(IX_LINE_CTL);
      5'b00_100: rd_code = c(IX_MODEM_CTL);
      5'b00_101: rd_code = c(IX_LINE_STS);
      5'b00_110: rd_code = c(IX_MODEM_STS);
      5'b00_111: rd_code = c(IX_AUX0);
      5'b01_000: rd_code = c(RC_RXDATA);
      5'b01_001: rd_code = c(RC_RXFRAME);
      5'b01_011: rd_code = c(RC_TIMER);
      5'b01_100: rd_code = c(RC_FIFO);
      5'b01_101: rd_code = c(RC_RXSTS);
      5'b01_110: rd_code = c(IX_MODEM_STS);
      5'b01_111: rd_code = c(RC_GEN);
      5'b10_001: rd_code = c(IX_FIFO_MODE);
      5'b10_011: rd_code = c(IX_TX_MODE);
      5'b10_100: rd_code = c(IX_IO_MODE);
      5'b10_101: rd_code = c(IX_AUX1);
      5'b10_110: rd_code = c(IX_RX_IE);
      5'b10_111: rd_code = c(IX_RX_MODE);
      5'b11_000: rd_code = dlab ? c(IX_BGB_LO) : c(IX_CLK_CFG);
      5'b11_001: rd_code = dlab ? c(IX_BGB_HI) : c(IX_BGA_CFG);
      5'b11_011: rd_code = c(IX_BGB_CFG);
      5'b11_100: rd_code = c(IX_PWR_MODE);
      5'b11_101: rd_code = c(IX_MODEM_IE);
      5'b11_110: rd_code = c(IX_TIMER_IE);
      default:   rd_code = (rd_addr == 3'b010) ? c(RC_IDENT) : c(CODE_NONE);
    endcase
  end
endmodule

// File: rtl/bankreg_store.sv
module bankreg_store
  import bankreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NWR-1:0] wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic [NSTS-1:0] sts_load,
  input  logic [DW-1:0] sts_data,
  output logic [DW-1:0] cfg [NCFG],
  output logic [DW-1:0] sts [NSTS],
  output logic [BW-1:0] bank,
  output logic          dlab
);
  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n)         cfg[i] <= cfg_default(i);
      else if (wr_stb[i]) cfg[i] <= wr_data;
    end
    // R6: a register changes only under its own strobe
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb[i] |=> $stable(cfg[i]));
  end

  for (genvar j = 0; j < NSTS; j++) begin : g_sts
    always_ff @(posedge clk) begin
      if (!rst_n)           sts[j] <= sts_default(j);
      else if (sts_load[j]) sts[j] <= sts_data;
    end
    // R9: a load copies the engine's value
    p_sts_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sts_load[j] |=> (sts[j] == $past(sts_data)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               bank <= '0;
    else if (wr_stb[WC_BANK]) bank <= wr_data[BANK_LSB +: BW];
  end

  assign dlab = cfg[IX_LINE_CTL][DLAB_BIT];

  // R2: the bank moves only on a bank-select write
  p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb[WC_BANK] |=> $stable(bank));
endmodule

// File: rtl/bankreg_bus.sv
module bankreg_bus
  import bankreg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_cs_n,
  input  logic                bus_rd_n,
  input  logic                bus_wr_n,
  input  logic [AW-1:0]       bus_addr,
  inout  wire  [DW-1:0]       bus_data,
  input  logic                irq_idle,
  input  logic [NSTS-1:0]     sts_load,
  input  logic [DW-1:0]       sts_data,
  output logic [NWR-1:0]      wr_stb,
  output logic [DW-1:0]       wr_data,
  output logic [NCFG*DW-1:0]  cfg_q
);
  logic          wr_evt;
  logic [AW-1:0] wr_addr;
  logic [CW-1:0] rd_code, wr_code;
  logic [DW-1:0] cfg [NCFG];
  logic [DW-1:0] sts [NSTS];
  logic [BW-1:0] bank;
  logic          dlab;
  logic [DW-1:0] rdata;
  logic          drive;

  bankreg_sampler u_samp (
    .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .wr_n(bus_wr_n),
    .addr(bus_addr), .data(bus_data),
    .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  bankreg_decode u_dec (
    .bank(bank), .dlab(dlab), .rd_addr(bus_addr), .wr_addr(wr_addr),
    .rd_code(rd_code), .wr_code(wr_code)
  );

  always_comb begin
    wr_stb = '0;
    if (wr_evt && int'(wr_code) < NWR) wr_stb[wr_code] = 1'b1;
  end

  bankreg_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .sts_load(sts_load), .sts_data(sts_data),
    .cfg(cfg), .sts(sts), .bank(bank), .dlab(dlab)
  );

  for (genvar i = 0; i < NCFG; i++) begin : g_flat
    assign cfg_q[i*DW +: DW] = cfg[i];
  end

  always_comb begin
    if (int'(rd_code) < NCFG)             rdata = cfg[rd_code];
    else if (int'(rd_code) < RC_IDENT)    rdata = sts[int'(rd_code) - NCFG];
    else if (int'(rd_code) == RC_IDENT)   rdata = {1'b0, bank, 4'b0000, irq_idle};
    else                                  rdata = '0;
  end

  assign drive    = !bus_cs_n && !bus_rd_n;
  assign bus_data = drive ? rdata : {DW{1'bz}};

  // R7: never two targets in one commit
  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));
  // R7: command writes leave every stored register untouched
  p_cmd_nostore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_stb[WC_TXFRAME:WC_IRQ]) |=> $stable(cfg_q));
endmodule

// File: tb/bankreg_bus_tb_top.sv
module bankreg_bus_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic [2:0] bus_addr = '0;
  wire  [7:0] bus_data;
  logic tb_en = 1'b0;
  logic [7:0] tb_drv = '0;
  logic irq_idle = 1'b1;
  logic [5:0] sts_load = '0;
  logic [7:0] sts_data = '0;
  logic [28:0] wr_stb;
  logic [7:0] wr_data;
  logic [175:0] cfg_q;

  assign bus_data = tb_en ? tb_drv : 8'hzz;
  always #4 clk = ~clk;

  bankreg_bus dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .irq_idle(irq_idle), .sts_load(sts_load), .sts_data(sts_data),
    .wr_stb(wr_stb), .wr_data(wr_data), .cfg_q(cfg_q)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0, mon_on = 1'b0;
  logic [7:0] cfg_m [22];
  logic [7:0] sts_m [6];
  logic [1:0] bank_m = 2'b00;

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic int m_wr_code(input logic [1:0] b, input logic d, input logic [2:0] a);
    if (a == 3'd2) return 28;
    case ({b, a})
      5'b00_000: return d ? 4 : 26;   5'b00_001: return d ? 3 : 10;
      5'b00_011: return 12;           5'b00_100: return 14;
      5'b00_101: return 13;           5'b00_110: return 16;
      5'b00_111: return 0;
      5'b01_000: return 26;           5'b01_001: return 27;
      5'b01_011: return 25;           5'b01_100: return 14;
      5'b01_101: return 23;           5'b01_110: return 24;
      5'b01_111: return 22;
      5'b10_001: return 9;            5'b10_011: return 20;
      5'b10_100: return 11;           5'b10_101: return 1;
      5'b10_110: return 18;           5'b10_111: return 19;
      5'b11_000: return d ? 7 : 8;    5'b11_001: return d ? 6 : 2;
      5'b11_011: return 5;            5'b11_100: return 17;
      5'b11_101: return 15;           5'b11_110: return 21;
      default:   return -1;
    endcase
  endfunction

  function automatic logic [7:0] m_read(input logic [1:0] b, input logic [2:0] a);
    logic d;
    d = cfg_m[12][7];
    if (a == 3'd2) return {1'b0, bank_m, 4'b0000, irq_idle};
    case ({b, a})
      5'b00_000: return d ? cfg_m[4] : sts_m[5];
      5'b01_000: return sts_m[5];
      5'b01_001: return sts_m[3];
      5'b01_011: return sts_m[4];
      5'b01_100: return sts_m[0];
      5'b01_101: return sts_m[2];
      5'b01_110: return cfg_m[16];
      5'b01_111: return sts_m[1];
      default: begin
        int c;
        c = m_wr_code(b, d, a);
        return (c >= 0 && c < 22) ? cfg_m[c] : 8'h00;
      end
    endcase
  endfunction

  always @(posedge clk) begin
    if (mon_on) begin
      #2;
      for (int i = 0; i < 22; i++)
        if (cfg_q[i*8 +: 8] !== cfg_m[i]) begin
          check(1'b0, $sformatf("R6 cfg_q byte %0d", i), cfg_q[i*8 +: 8], cfg_m[i]);
        end
      checks++;
    end
  end

  task automatic wr_bus(input logic [2:0] a, input logic [7:0] v, input bit sel, input int code);
    logic [28:0] exp;
    @(negedge clk);
    bus_cs_n = !sel; bus_addr = a; tb_drv = v; tb_en = 1'b1; bus_wr_n = 1'b0;
    repeat (2) @(negedge clk);
    bus_wr_n = 1'b1;
    @(negedge clk);
    exp = (code < 0) ? 29'd0 : (29'd1 << code);
    check(wr_stb == exp, (code >= 22 && code < 28) ? "R7 strobe" : "R6 strobe", wr_stb, exp);
    if (code >= 0) check(wr_data == v, "R6 wr_data", wr_data, v);
    if (code >= 0 && code < 22) cfg_m[code] = v;
    if (code == 28) bank_m = v[6:5];
    bus_cs_n = 1'b1; tb_en = 1'b0;
    @(negedge clk);
    check(wr_stb == 29'd0, "R6 single pulse", wr_stb, 0);
  endtask

  task automatic rd_bus(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_cs_n = 1'b0; bus_rd_n = 1'b0; bus_addr = a;
    #2 v = bus_data;
    bus_cs_n = 1'b1; bus_rd_n = 1'b1;
  endtask

  task automatic sel_bank(input logic [1:0] b);
    wr_bus(3'd2, {1'b0, b, 5'b0}, 1'b1, 28);
  endtask

  task automatic rd_sweep();
    logic [7:0] v;
    string tag;
    for (int b = 0; b < 4; b++) begin
      sel_bank(2'(b));
      for (int a = 0; a < 8; a++) begin
        rd_bus(3'(a), v);
        tag = (a == 2) ? "R2" : (b == 0) ? "R3" : (b == 1) ? "R5" : (b == 3) ? "R4" : "R6";
        check(v == m_read(2'(b), 3'(a)), $sformatf("%s read b%0d a%0d", tag, b, a), v, m_read(2'(b), 3'(a)));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 22; i++) cfg_m[i] = 8'h00;
    cfg_m[2] = 8'h04; cfg_m[4] = 8'h02; cfg_m[5] = 8'h84; cfg_m[7] = 8'h05;
    cfg_m[11] = 8'h0C; cfg_m[13] = 8'h60; cfg_m[15] = 8'h0F; cfg_m[17] = 8'hFC; cfg_m[18] = 8'h1E;
    for (int j = 0; j < 6; j++) sts_m[j] = 8'h00;
    sts_m[1] = 8'h12; sts_m[4] = 8'h30;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values on the configuration outputs
    for (int i = 0; i < 22; i++)
      check(cfg_q[i*8 +: 8] == cfg_m[i], $sformatf("R1 default %0d", i), cfg_q[i*8 +: 8], cfg_m[i]);
    rd_bus(3'd2, v);
    check(v == 8'h01, "R1 R2 ident at reset", v, 8'h01);
    mon_on = 1'b1;
    rd_sweep();                       // R1 status defaults, R3 R4 R5 with latch bit 0

    // R8: bus released when not both selected and reading
    sel_bank(2'd0);
    @(negedge clk);
    bus_addr = 3'd2; tb_drv = 8'hC3; tb_en = 1'b1; bus_cs_n = 1'b1; bus_rd_n = 1'b0;
    #2 check(bus_data == 8'hC3, "R8 cs high", bus_data, 8'hC3);
    bus_cs_n = 1'b0; bus_rd_n = 1'b1;
    #2 check(bus_data == 8'hC3, "R8 rd high", bus_data, 8'hC3);
    bus_cs_n = 1'b1; tb_en = 1'b0;

    // R3: latch bit set exposes divisors
    wr_bus(3'd3, 8'h80, 1'b1, 12);
    rd_sweep();

    // pattern writes to every address with each latch setting
    for (int d = 1; d >= 0; d--) begin
      sel_bank(2'd0);
      wr_bus(3'd3, {d[0], 7'h15}, 1'b1, 12);
      for (int b = 0; b < 4; b++) begin
        sel_bank(2'(b));
        for (int a = 0; a < 8; a++) begin
          if (a == 2 || (b == 0 && a == 3)) continue;
          v = 8'(((b << 4) | (d << 3) | a) ^ 8'hA5);
          wr_bus(3'(a), v, 1'b1, m_wr_code(2'(b), d[0], 3'(a)));
        end
      end
      rd_sweep();
    end

    // R6: write without chip select is dropped
    sel_bank(2'd2);
    wr_bus(3'd1, 8'h3C, 1'b0, -1);
    rd_bus(3'd1, v);
    check(v == cfg_m[9], "R6 unselected write", v, cfg_m[9]);

    // R9: status loads
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      sts_load = 6'(1 << j); sts_data = 8'(8'h40 + j * 8'h11);
      @(negedge clk);
      sts_m[j] = sts_data; sts_load = '0;
    end
    sel_bank(2'd1);
    for (int a = 0; a < 8; a++) begin
      rd_bus(3'(a), v);
      check(v == m_read(2'd1, 3'(a)), $sformatf("R9 status read a%0d", a), v, m_read(2'd1, 3'(a)));
    end

    // R7: command write leaves shared read intact
    wr_bus(3'd7, 8'hFF, 1'b1, 22);
    rd_bus(3'd7, v);
    check(v == sts_m[1], "R7 irq cmd vs gen_sts", v, sts_m[1]);
    wr_bus(3'd5, 8'hEE, 1'b1, 23);
    rd_bus(3'd5, v);
    check(v == sts_m[2], "R7 rx cmd vs rx_sts", v, sts_m[2]);

    irq_idle = 1'b0;
    rd_bus(3'd2, v);
    check(v == {1'b0, 2'd1, 5'd0}, "R2 ident bank1 irq low", v, {1'b0, 2'd1, 5'd0});

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule